// File: doc/BRIEF.md
# Multi-Period Input Capture Meter

The block measures how long a square wave takes to complete a fixed number of periods. A start command loads a 16-bit timer with all ones and starts it. The timer then counts down once for each clock on which the tick enable is high. The signal input is synchronized and edge-detected. Each selected edge copies the timer value into a capture register and sets a pending flag. The timer keeps running and is not altered by the copy.

The first capture becomes the start value. After that the block counts a fixed number of further edges (20 by default). The last of these captures becomes the end value. Capture is then shut off and the timer is halted. The block publishes start minus end, which is the number of ticks spanned by those periods, and pulses done for one clock. If the timer runs past zero before the end capture, the run is abandoned and an overflow flag is raised. Dividing the result by the period count and converting it to time units is left to the consumer.

Top module: `period_meter`

## Requirements
- R1: After reset, elapsed_o is 0 and done_o and ovf_o are 0. No measurement runs until start_i is seen.
- R2: A clock with start_i high loads the timer with 0xFFFF and clears the result, done_o, ovf_o, any pending capture and the edge count. This holds whatever state the block was in.
- R3: The timer counts down by one only on clocks where tick_i is 1, so the result is a count of ticks. With tick_i high every second clock and a 12-clock input period, the result for 20 periods is 120.
- R4: With fall_sel_i = 0, capture happens on rising edges of sig_i. With tick_i always 1 and a 10-clock period, the result is 200.
- R5: With fall_sel_i = 1, capture happens on falling edges of sig_i instead. The result does not depend on the duty cycle.
- R6: The first capture after start is the start value. The 20th capture after it is the end value. elapsed_o equals start value minus end value.
- R7: done_o is high for exactly one clock per completed measurement, and that clock is the one on which elapsed_o takes its new value.
- R8: After the end capture, further input edges change neither elapsed_o nor done_o until the next start.
- R9: If the timer would pass below zero before the end capture, ovf_o goes to 1 and stays there. done_o never pulses for that run, and elapsed_o stays 0.
- R10: Edges two clocks apart, which is the fastest a synchronized input can produce, are all counted. An input toggling on every clock gives a result of 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer count enable, one tick per high clock |
| start_i | input | 1 | Begin a new measurement and clear all prior state |
| fall_sel_i | input | 1 | Edge select: 0 for rising edges, 1 for falling edges |
| sig_i | input | 1 | Asynchronous square wave under measurement |
| elapsed_o | output | 16 | Ticks between the start capture and the end capture |
| done_o | output | 1 | One-clock pulse when a valid result is published |
| ovf_o | output | 1 | Timer wrapped before the end capture; result invalid |

## Verification
The assertions check the following on every clock:
- the timer preset on start;
- the timer holding still on clocks without a tick;
- done staying a single-clock pulse;
- done never rising while overflow is set;
- the result staying frozen once the block is finished;
- a fixed edge polarity never producing edge pulses on adjacent clocks.

Only the bench scenarios can show that the published count matches the true number of ticks across 20 periods. The same holds for the falling-edge option, for throttled ticks, for edges at the fastest legal spacing, and for overflow on a slow input. The bench shows these by comparing against a behavioural model on every clock and against closed-form expected counts.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    PM_IDLE,
    PM_ARM,
    PM_MEAS,
    PM_DONE
  } pm_state_e;
endpackage

// File: rtl/pm_edge_sync.sv
module pm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  // q[STAGES-1] is the synchronized level, q[STAGES] is its previous value
  logic [STAGES:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= {q[STAGES-1:0], sig_i};
  end

  assign edge_o = fall_sel_i ? (!q[STAGES-1] &&  q[STAGES])
                             : ( q[STAGES-1] && !q[STAGES]);

  // With a steady polarity, two edge pulses are always at least two clocks apart
  assert_edge_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_o && fall_sel_i == $past(fall_sel_i)) |=>
      (!edge_o || fall_sel_i != $past(fall_sel_i)));
endmodule

// File: rtl/pm_capture_timer.sv
module pm_capture_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         cap_en_i,
  input  logic         edge_i,
  input  logic         consume_i,
  output logic [W-1:0] tmr_o,
  output logic [W-1:0] cap_o,
  output logic         pend_o
);
  logic [W-1:0] tmr_q, cap_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tmr_q <= '0;
    else if (load_i)            tmr_q <= '1;
    else if (run_i && tick_i)   tmr_q <= tmr_q - 1'b1;
  end

  // A new capture outranks consumption of the previous one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      cap_q  <= '0;
      pend_q <= 1'b0;
    end else if (cap_en_i && edge_i) begin
      cap_q  <= tmr_q;
      pend_q <= 1'b1;
    end else if (consume_i) begin
      pend_q <= 1'b0;
    end
  end

  assign tmr_o  = tmr_q;
  assign cap_o  = cap_q;
  assign pend_o = pend_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> tmr_q == {W{1'b1}});
  assert_tick_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(tmr_q));
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int W         = 16,
  parameter int N_PERIODS = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         tick_i,
  input  logic [W-1:0] tmr_i,
  input  logic [W-1:0] cap_i,
  input  logic         pend_i,
  output logic         run_o,
  output logic         cap_en_o,
  output logic         consume_o,
  output logic [W-1:0] elapsed_o,
  output logic         done_o,
  output logic         ovf_o
);
  localparam int CW   = (N_PERIODS > 1) ? $clog2(N_PERIODS) : 1;
  localparam int LAST = N_PERIODS - 1;

  pm_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  start_val_q, elapsed_q;
  logic          run_q, done_q, ovf_q;
  logic          armed, wrap, fin;

  assign armed     = (state_q == PM_ARM) || (state_q == PM_MEAS);
  assign wrap      = armed && run_q && tick_i && (tmr_i == '0);
  assign fin       = (state_q == PM_MEAS) && pend_i && (cnt_q == CW'(LAST));
  assign cap_en_o  = armed && !fin && !wrap && !start_i;
  assign consume_o = armed && pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PM_IDLE;
      cnt_q       <= '0;
      start_val_q <= '0;
      elapsed_q   <= '0;
      run_q       <= 1'b0;
      done_q      <= 1'b0;
      ovf_q       <= 1'b0;
    end else if (start_i) begin
      state_q     <= PM_ARM;
      cnt_q       <= '0;
      start_val_q <= '0;
      elapsed_q   <= '0;
      run_q       <= 1'b1;
      done_q      <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      done_q <= fin && !wrap;
      if (wrap) begin
        ovf_q   <= 1'b1;
        run_q   <= 1'b0;
        state_q <= PM_IDLE;
      end else if (consume_o) begin
        if (state_q == PM_ARM) begin
          start_val_q <= cap_i;
          cnt_q       <= '0;
          state_q     <= PM_MEAS;
        end else if (fin) begin
          elapsed_q <= start_val_q - cap_i;
          run_q     <= 1'b0;
          state_q   <= PM_DONE;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign run_o     = run_q;
  assign elapsed_o = elapsed_q;
  assign done_o    = done_q;
  assign ovf_o     = ovf_q;

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_ovf_no_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> !done_q);
  assert_hold_result_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DONE && !start_i) |=> $stable(elapsed_q));
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int W         = 16,
  parameter int N_PERIODS = 20,
  parameter int SYNC      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic         fall_sel_i,
  input  logic         sig_i,
  output logic [W-1:0] elapsed_o,
  output logic         done_o,
  output logic         ovf_o
);
  logic         edge_w, run_w, cap_en_w, consume_w, pend_w;
  logic [W-1:0] tmr_w, cap_w;

  pm_edge_sync #(.STAGES(SYNC)) i_sync (
    .clk_i, .rst_ni, .sig_i, .fall_sel_i, .edge_o(edge_w)
  );

  pm_capture_timer #(.W(W)) i_timer (
    .clk_i, .rst_ni,
    .load_i(start_i), .run_i(run_w), .tick_i,
    .cap_en_i(cap_en_w), .edge_i(edge_w), .consume_i(consume_w),
    .tmr_o(tmr_w), .cap_o(cap_w), .pend_o(pend_w)
  );

  pm_ctrl #(.W(W), .N_PERIODS(N_PERIODS)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .tick_i,
    .tmr_i(tmr_w), .cap_i(cap_w), .pend_i(pend_w),
    .run_o(run_w), .cap_en_o(cap_en_w), .consume_o(consume_w),
    .elapsed_o, .done_o, .ovf_o
  );
endmodule

// File: tb/test_period_meter.sv
module test_period_meter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        start_i = 1'b0;
  logic        fall_sel_i = 1'b0;
  logic        sig_i = 1'b0;
  logic [15:0] elapsed_o;
  logic        done_o, ovf_o;

  int vectors = 0, miscompares = 0, done_cnt = 0;
  bit tick_half = 1'b0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  period_meter i_period_meter (
    .clk_i, .rst_ni, .tick_i, .start_i, .fall_sel_i, .sig_i,
    .elapsed_o, .done_o, .ovf_o
  );

  always @(negedge clk_i) tick_i = tick_half ? !tick_i : 1'b1;

  // Behavioural reference, updated on every rising edge
  int m_s1, m_s2, m_s3, m_tmr, m_ph, m_n, m_start, m_cap, m_el;
  bit m_run, m_pend, m_done, m_ovf;
  always @(posedge clk_i) begin
    bit e, wrap, fin, capen, o_pend;
    int o_tmr, o_cap;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_tmr = 0; m_ph = 0; m_n = 0;
      m_start = 0; m_cap = 0; m_el = 0; m_run = 0; m_pend = 0;
      m_done = 0; m_ovf = 0;
    end else begin
      e = fall_sel_i ? (m_s2 == 0 && m_s3 == 1) : (m_s2 == 1 && m_s3 == 0);
      m_done = 0;
      if (start_i) begin
        m_tmr = 65535; m_run = 1; m_ph = 1; m_n = 0; m_pend = 0;
        m_cap = 0; m_el = 0; m_ovf = 0; m_start = 0;
      end else begin
        wrap  = m_run && tick_i && m_tmr == 0 && (m_ph == 1 || m_ph == 2);
        fin   = m_ph == 2 && m_pend && m_n == 19;
        capen = (m_ph == 1 || m_ph == 2) && !fin && !wrap;
        o_tmr = m_tmr; o_pend = m_pend; o_cap = m_cap;
        if (m_run && tick_i) m_tmr = (m_tmr - 1) & 16'hFFFF;
        if (capen && e) begin m_cap = o_tmr; m_pend = 1; end
        else if (o_pend && (m_ph == 1 || m_ph == 2)) m_pend = 0;
        if (wrap) begin
          m_ovf = 1; m_run = 0; m_ph = 0;
        end else if (o_pend && (m_ph == 1 || m_ph == 2)) begin
          if (m_ph == 1) begin m_start = o_cap; m_ph = 2; m_n = 0; end
          else if (fin) begin
            m_el = (m_start - o_cap) & 16'hFFFF; m_done = 1; m_ph = 3; m_run = 0;
          end else m_n++;
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sig_i;
    end
  end

  always @(posedge clk_i) begin
    #2;
    if (rst_ni && !finished) begin
      vectors++;
      if (done_o) done_cnt++;
      if (elapsed_o !== 16'(m_el) || done_o !== m_done || ovf_o !== m_ovf) begin
        miscompares++;
        $display("FAIL R6 model t=%0t: act el=%0d done=%0b ovf=%0b exp el=%0d done=%0b ovf=%0b",
                 $time, elapsed_o, done_o, ovf_o, m_el, m_done, m_ovf);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    chk("R2 elapsed cleared", elapsed_o, 0);
    chk("R2 ovf cleared", ovf_o, 0);
    chk("R2 no done", done_o, 0);
  endtask

  task automatic wave(int hi, int lo, int count);
    for (int i = 0; i < count; i++) begin
      sig_i = 1'b1;
      repeat (hi) @(negedge clk_i);
      sig_i = 1'b0;
      repeat (lo) @(negedge clk_i);
    end
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    miscompares++;
    $display("FAIL watchdog: act running exp finished");
    summary();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 elapsed", elapsed_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 ovf", ovf_o, 0);

    // R4, R6, R7: rising edges, 10-clock period
    d0 = done_cnt;
    do_start();
    wave(5, 5, 24);
    repeat (6) @(negedge clk_i);
    chk("R4 rising 20x10", elapsed_o, 200);
    chk("R7 one done", done_cnt - d0, 1);
    // R8: later edges ignored
    wave(5, 5, 3);
    repeat (6) @(negedge clk_i);
    chk("R8 result frozen", elapsed_o, 200);
    chk("R8 no extra done", done_cnt - d0, 1);

    // R3: tick every second clock
    tick_half = 1'b1;
    d0 = done_cnt;
    do_start();
    wave(6, 6, 24);
    repeat (6) @(negedge clk_i);
    chk("R3 half-rate ticks", elapsed_o, 120);
    chk("R7 done half-rate", done_cnt - d0, 1);
    tick_half = 1'b0;

    // R5: falling edges, asymmetric duty
    fall_sel_i = 1'b1;
    d0 = done_cnt;
    do_start();
    wave(3, 7, 24);
    repeat (6) @(negedge clk_i);
    chk("R5 falling 20x10", elapsed_o, 200);
    chk("R5 done", done_cnt - d0, 1);
    fall_sel_i = 1'b0;

    // R10: toggling every clock
    d0 = done_cnt;
    do_start();
    wave(1, 1, 26);
    repeat (6) @(negedge clk_i);
    chk("R10 min spacing", elapsed_o, 40);
    chk("R10 done", done_cnt - d0, 1);

    // R9: slow input wraps the timer
    d0 = done_cnt;
    do_start();
    wave(2000, 2000, 18);
    chk("R9 ovf set", ovf_o, 1);
    chk("R9 no done", done_cnt - d0, 0);
    chk("R9 elapsed zero", elapsed_o, 0);

    // R2 then R6: restart clears overflow and measures again
    d0 = done_cnt;
    do_start();
    wave(4, 4, 23);
    repeat (6) @(negedge clk_i);
    chk("R6 restart 20x8", elapsed_o, 160);
    chk("R6 done", done_cnt - d0, 1);
    chk("R2 ovf stays clear", ovf_o, 0);

    summary();
  end
endmodule